// File: doc/BRIEF.md
# Bandwidth Slot-Table Builder

This engine fills the slot table of a time-sliced memory arbiter. Each table entry names the client that owns one access slot. The engine works from three inputs: a requested slot count for each client, an active flag for each client, and a count of spare slots. After a start strobe it builds the table in an internal scratch array in two passes, then streams the finished table to the arbiter's slot RAM through a simple write port and raises a one-cycle done pulse.

The first pass takes clients in ascending index order. A client that asks for r slots is spread through the table by walking from slot 0. The walk jumps by the integer interval (slot count / r) after each placement and steps by one past occupied entries. A client that asks for nothing but is active gets a single slot while the spare count lasts. The second pass visits every slot in order and hands each still-empty slot to the next active client after a rotating pointer. Every final entry is written out in this pass. A combinational flag reports when the requests together exceed the table size. The inputs must be held stable from start until done.

Top module: `slot_table_builder`

## Requirements
- R1: While reset is held and on the first cycle after it, wr_en_o and done_o are low.
- R2: Clients with a non-zero request r are placed in ascending index order. Each walk starts at slot 0. An occupied slot moves the walk on by one. An empty slot takes the client and moves the walk on by 64/r (integer division). The walk ends at position 64 or beyond.
- R3: A client with request 0 takes exactly one slot, found by the same walk with interval 64, only if it is active and the remaining spare count is above zero. Each such grant lowers the spare count by one. Inactive clients and clients that arrive after the spares are gone take no slot in the first pass.
- R4: In the second pass, slots 0 to 63 are visited in order. Each slot still empty goes to the first active client at or after a rotating pointer. The pointer starts at 0 and then moves to the chosen client plus one, modulo 15.
- R5: If no client is active, an empty slot takes the pointer value itself, and the pointer then advances by one modulo 15.
- R6: Each run writes every slot exactly once, in ascending address order from 0 to 63, on consecutive cycles. wr_data_o carries the final client index, which is always below 15.
- R7: done_o is high for exactly one cycle, the cycle right after the write of slot 63, and no write happens in that cycle.
- R8: A start strobe that arrives while a run is in progress has no effect. The run still writes each slot once, and the written table is unchanged.
- R9: overflow_o is high exactly when the sum of all requests is greater than 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a table build (ignored while busy) |
| req_i | input | 105 | Requested slot count, 7 bits per client, client 0 in the low bits |
| active_i | input | 15 | Active flag per client, bit n is client n |
| spare_i | input | 7 | Spare slots available to zero-request clients |
| wr_en_o | output | 1 | Slot RAM write enable |
| wr_addr_o | output | 6 | Slot RAM write address |
| wr_data_o | output | 4 | Client index written into the slot |
| done_o | output | 1 | One-cycle pulse after the last slot write |
| overflow_o | output | 1 | Sum of requests exceeds the table size |

## Verification
The bench aims at requests whose walks collide. A design that skipped occupied entries by the interval instead of by one would leave holes and shift clients to the wrong slots. Zero-request clients are tested with the spare count above zero, at zero, and running out partway through. A design that ignored the spare count or the active flag would hand out extra slots. The all-inactive case catches a pointer that fails to advance when its search finds nothing, because such a design writes the same index into every slot instead of counting 0 to 14. A second start during a run would restart a design that does not ignore it, and the write count would show it.

// File: rtl/slot_alloc_pkg.sv
// Shared types of the slot-table builder.
// Assumes nothing beyond a synthesizable enum encoding.
package slot_alloc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WALK,
        ST_FILL,
        ST_FIN
    } build_state_t;
endpackage

// File: rtl/slot_interval.sv
// Decides whether the current client takes part in the first pass and with
// which stride. Assumes req_i is at most NUM_SLOTS when non-zero.
module slot_interval #(
    parameter int NUM_SLOTS = 64,
    parameter int REQ_W     = 7,
    parameter int POS_W     = 8
) (
    input  logic [REQ_W-1:0] req_i,
    input  logic             active_i,
    input  logic             spare_nz_i,
    output logic             take_o,
    output logic             zero_take_o,
    output logic [POS_W-1:0] interval_o
);
    // Participation and stride for the client under consideration.
    always_comb begin
        zero_take_o = (req_i == '0) && active_i && spare_nz_i;
        take_o      = (req_i != '0) || zero_take_o;
        if (req_i == '0)
            interval_o = POS_W'(NUM_SLOTS);
        else
            interval_o = POS_W'(NUM_SLOTS) / POS_W'(req_i);
    end
endmodule

// File: rtl/slot_rr_pick.sv
// Finds the first active client at or after a start pointer, wrapping
// modulo NUM_CLIENTS; returns the pointer itself when none is active.
// Assumes ptr_i < NUM_CLIENTS.
module slot_rr_pick #(
    parameter int NUM_CLIENTS = 15,
    parameter int CLI_W       = 4
) (
    input  logic [CLI_W-1:0]       ptr_i,
    input  logic [NUM_CLIENTS-1:0] active_i,
    output logic [CLI_W-1:0]       pick_o
);
    logic       found;
    logic [CLI_W:0] idx;

    // Rotating priority search over one full lap.
    always_comb begin
        pick_o = ptr_i;
        found  = 1'b0;
        idx    = '0;
        for (int k = 0; k < NUM_CLIENTS; k++) begin
            idx = {1'b0, ptr_i} + (CLI_W+1)'(k);
            if (idx >= (CLI_W+1)'(NUM_CLIENTS))
                idx = idx - (CLI_W+1)'(NUM_CLIENTS);
            if (!found && active_i[idx[CLI_W-1:0]]) begin
                pick_o = idx[CLI_W-1:0];
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/slot_req_sum.sv
// Sums all per-client requests and flags a total above the table size.
// Assumes the packed request vector holds client 0 in the low bits.
module slot_req_sum #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 15,
    parameter int REQ_W       = 7
) (
    input  logic [NUM_CLIENTS*REQ_W-1:0] req_i,
    output logic                         overflow_o
);
    localparam int SUM_W = REQ_W + $clog2(NUM_CLIENTS) + 1;
    logic [SUM_W-1:0] total;

    // Total demand compared against the table capacity.
    always_comb begin
        total = '0;
        for (int c = 0; c < NUM_CLIENTS; c++)
            total = total + SUM_W'(req_i[c*REQ_W +: REQ_W]);
        overflow_o = total > SUM_W'(NUM_SLOTS);
    end
endmodule

// File: rtl/slot_table_builder.sv
// Two-pass slot-table builder. Pass one spreads requested slots and grants
// spare single slots to idle-request active clients; pass two fills empty
// entries round-robin and streams the table to slot RAM in address order.
// Assumes req_i, active_i and spare_i stay stable from start until done.
module slot_table_builder
    import slot_alloc_pkg::*;
#(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 15
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           start_i,
    input  logic [NUM_CLIENTS*($clog2(NUM_SLOTS)+1)-1:0]   req_i,
    input  logic [NUM_CLIENTS-1:0]                         active_i,
    input  logic [$clog2(NUM_SLOTS):0]                     spare_i,
    output logic                                           wr_en_o,
    output logic [$clog2(NUM_SLOTS)-1:0]                   wr_addr_o,
    output logic [$clog2(NUM_CLIENTS)-1:0]                 wr_data_o,
    output logic                                           done_o,
    output logic                                           overflow_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int REQ_W  = SLOT_W + 1;
    localparam int POS_W  = SLOT_W + 2;
    localparam int CLI_W  = $clog2(NUM_CLIENTS);

    build_state_t             st;
    logic [CLI_W-1:0]         cli;
    logic [POS_W-1:0]         pos;
    logic [POS_W-1:0]         step;
    logic [REQ_W-1:0]         spare_q;
    logic [SLOT_W-1:0]        slot;
    logic [CLI_W-1:0]         ptr;
    logic [NUM_SLOTS-1:0]     tbl_vld;
    logic [CLI_W-1:0]         tbl_cli [NUM_SLOTS];

    logic [REQ_W-1:0]         cur_req;
    logic                     take, zero_take;
    logic [POS_W-1:0]         interval;
    logic [CLI_W-1:0]         pick;
    logic [SLOT_W-1:0]        walk_idx;
    logic                     last_cli;

    // Request of the client currently handled by pass one.
    always_comb begin
        cur_req  = req_i[cli*REQ_W +: REQ_W];
        walk_idx = pos[SLOT_W-1:0];
        last_cli = (cli == CLI_W'(NUM_CLIENTS-1));
    end

    slot_interval #(.NUM_SLOTS(NUM_SLOTS), .REQ_W(REQ_W), .POS_W(POS_W)) u_intv (
        .req_i       (cur_req),
        .active_i    (active_i[cli]),
        .spare_nz_i  (spare_q != '0),
        .take_o      (take),
        .zero_take_o (zero_take),
        .interval_o  (interval)
    );

    slot_rr_pick #(.NUM_CLIENTS(NUM_CLIENTS), .CLI_W(CLI_W)) u_pick (
        .ptr_i    (ptr),
        .active_i (active_i),
        .pick_o   (pick)
    );

    slot_req_sum #(.NUM_SLOTS(NUM_SLOTS), .NUM_CLIENTS(NUM_CLIENTS), .REQ_W(REQ_W)) u_sum (
        .req_i      (req_i),
        .overflow_o (overflow_o)
    );

    // Sequencer of both passes and the slot RAM write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cli       <= '0;
            pos       <= '0;
            step      <= '0;
            spare_q   <= '0;
            slot      <= '0;
            ptr       <= '0;
            tbl_vld   <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            done_o  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        tbl_vld <= '0;
                        cli     <= '0;
                        spare_q <= spare_i;
                        st      <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (take) begin
                        pos  <= '0;
                        step <= interval;
                        if (zero_take)
                            spare_q <= spare_q - 1'b1;
                        st <= ST_WALK;
                    end else if (last_cli) begin
                        slot <= '0;
                        ptr  <= '0;
                        st   <= ST_FILL;
                    end else begin
                        cli <= cli + 1'b1;
                    end
                end
                ST_WALK: begin
                    if (pos >= POS_W'(NUM_SLOTS)) begin
                        if (last_cli) begin
                            slot <= '0;
                            ptr  <= '0;
                            st   <= ST_FILL;
                        end else begin
                            cli <= cli + 1'b1;
                            st  <= ST_SETUP;
                        end
                    end else if (tbl_vld[walk_idx]) begin
                        pos <= pos + 1'b1;
                    end else begin
                        tbl_vld[walk_idx] <= 1'b1;
                        tbl_cli[walk_idx] <= cli;
                        pos               <= pos + step;
                    end
                end
                ST_FILL: begin
                    wr_en_o   <= 1'b1;
                    wr_addr_o <= slot;
                    if (tbl_vld[slot]) begin
                        wr_data_o <= tbl_cli[slot];
                    end else begin
                        wr_data_o <= pick;
                        ptr <= (pick == CLI_W'(NUM_CLIENTS-1)) ? '0 : pick + 1'b1;
                    end
                    if (slot == SLOT_W'(NUM_SLOTS-1))
                        st <= ST_FIN;
                    else
                        slot <= slot + 1'b1;
                end
                ST_FIN: begin
                    done_o <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slot_table_checker.sv
// Protocol checks on the slot RAM write port and the done pulse.
// Assumes reset is held for at least one clock edge.
module slot_table_checker #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 15
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en_o,
    input logic [$clog2(NUM_SLOTS)-1:0]   wr_addr_o,
    input logic [$clog2(NUM_CLIENTS)-1:0] wr_data_o,
    input logic                           done_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int CLI_W  = $clog2(NUM_CLIENTS);

    AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == SLOT_W'($past(wr_addr_o) + 1'b1))); // R6
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en_o) |-> (wr_addr_o == '0)); // R6
    AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_data_o < CLI_W'(NUM_CLIENTS))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_en_o) && ($past(wr_addr_o) == SLOT_W'(NUM_SLOTS-1)) && !wr_en_o)); // R7
endmodule

bind slot_table_builder slot_table_checker #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_CLIENTS (NUM_CLIENTS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .done_o    (done_o)
);

// File: tb/tb_slot_table_builder.sv
// Self-checking bench: directed corner cases plus seeded random requests,
// compared against a behavioural model of both allocation passes.
module tb_slot_table_builder;
    localparam int NS = 64;
    localparam int NC = 15;
    localparam int RW = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [NC*RW-1:0] req_i = '0;
    logic [NC-1:0]   active_i = '0;
    logic [RW-1:0]   spare_i = '0;
    logic            wr_en_o;
    logic [5:0]      wr_addr_o;
    logic [3:0]      wr_data_o;
    logic            done_o;
    logic            overflow_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int req_a [NC];
    bit act_a [NC];
    int spare_v;
    int exp_tbl [NS];
    int got_tbl [NS];
    int wcount, exp_next, done_cnt;
    bit order_bad, done_bad, prev_we;
    int prev_addr;

    always #4 clk = ~clk;

    slot_table_builder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
        .active_i(active_i), .spare_i(spare_i), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o),
        .overflow_o(overflow_o)
    );

    // Watchdog: an expired run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Write-port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en_o) begin
                got_tbl[wr_addr_o] = int'(wr_data_o);
                if (int'(wr_addr_o) != exp_next) order_bad = 1'b1;
                exp_next++;
                wcount++;
            end
            if (done_o) begin
                done_cnt++;
                if (!(prev_we && prev_addr == NS-1) || wr_en_o) done_bad = 1'b1;
            end
            prev_we   = wr_en_o;
            prev_addr = int'(wr_addr_o);
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural model of both passes.
    task automatic build_model();
        int s = spare_v;
        int c2 = 0;
        for (int k = 0; k < NS; k++) exp_tbl[k] = -1;
        for (int c = 0; c < NC; c++) begin
            int iv;
            int p;
            if (req_a[c] == 0) begin
                if (!act_a[c] || s <= 0) continue;
                s--;
                iv = NS;
            end else begin
                iv = NS / req_a[c];
            end
            p = 0;
            while (p < NS) begin
                if (exp_tbl[p] >= 0) p++;
                else begin
                    exp_tbl[p] = c;
                    p += iv;
                end
            end
        end
        for (int k = 0; k < NS; k++) begin
            if (exp_tbl[k] < 0) begin
                int first = c2;
                while (!act_a[c2]) begin
                    c2 = (c2 + 1) % NC;
                    if (c2 == first) break;
                end
                exp_tbl[k] = c2;
                c2 = (c2 + 1) % NC;
            end
        end
    endtask

    function automatic int req_total();
        int t = 0;
        for (int c = 0; c < NC; c++) t += req_a[c];
        return t;
    endfunction

    task automatic run_case(string tag, bit restart_mid);
        int mism = 0;
        int first_bad = -1;
        int wait_c = 0;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            req_i[c*RW +: RW] = RW'(req_a[c]);
            active_i[c] = act_a[c];
        end
        spare_i = RW'(spare_v);
        build_model();
        wcount = 0; exp_next = 0; done_cnt = 0;
        order_bad = 1'b0; done_bad = 1'b0;
        for (int k = 0; k < NS; k++) got_tbl[k] = -1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (restart_mid) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_cnt == 0 && wait_c < 10000) begin
            @(negedge clk);
            wait_c++;
        end
        repeat (3) @(negedge clk);
        check(!overflow_o == !(req_total() > NS), "R9", "overflow flag",
              int'(overflow_o), int'(req_total() > NS));
        for (int k = 0; k < NS; k++)
            if (got_tbl[k] != exp_tbl[k]) begin
                mism++;
                if (first_bad < 0) first_bad = k;
            end
        if (first_bad >= 0)
            check(1'b0, tag, $sformatf("slot %0d client", first_bad),
                  got_tbl[first_bad], exp_tbl[first_bad]);
        else
            check(1'b1, tag, "table", 0, 0);
        check(wcount == NS && !order_bad, restart_mid ? "R8" : "R6", "write count in order",
              wcount, NS);
        check(done_cnt == 1 && !done_bad, "R7", "done pulses", done_cnt, 1);
    endtask

    task automatic clear_inputs();
        for (int c = 0; c < NC; c++) begin
            req_a[c] = 0;
            act_a[c] = 1'b0;
        end
        spare_v = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < NS; k++) got_tbl[k] = -1;
        wcount = 0; exp_next = 0; done_cnt = 0; prev_we = 1'b0; prev_addr = 0;
        repeat (3) @(negedge clk);
        check(!wr_en_o && !done_o, "R1", "outputs in reset", int'(wr_en_o | done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en_o && !done_o, "R1", "outputs after reset", int'(wr_en_o | done_o), 0);

        // R5: nothing active, slot k takes k mod 15.
        clear_inputs();
        run_case("R5", 1'b0);
        check(got_tbl[16] == 1, "R5", "slot 16 wraps", got_tbl[16], 1);

        // R4: two active zero-request clients, no spares.
        clear_inputs();
        act_a[11] = 1'b1; act_a[12] = 1'b1;
        run_case("R4", 1'b0);
        check(got_tbl[2] == 11, "R4", "slot 2 alternates", got_tbl[2], 11);

        // R2: colliding strides.
        clear_inputs();
        req_a[3] = 5; act_a[3] = 1'b1;
        req_a[5] = 16; act_a[5] = 1'b1;
        req_a[8] = 7;
        run_case("R2", 1'b0);
        check(got_tbl[1] == 5, "R2", "collision shifts to slot 1", got_tbl[1], 5);

        // R3: spares run out part way.
        clear_inputs();
        req_a[0] = 8; act_a[0] = 1'b1;
        act_a[2] = 1'b1; act_a[6] = 1'b1; act_a[9] = 1'b1;
        req_a[4] = 0;
        spare_v = 2;
        run_case("R3", 1'b0);
        check(got_tbl[1] == 2, "R3", "first spare grant", got_tbl[1], 2);

        // R3: spare count zero, no early grants.
        spare_v = 0;
        run_case("R3", 1'b0);

        // R9: oversubscribed requests.
        clear_inputs();
        req_a[0] = 40; req_a[1] = 30; act_a[1] = 1'b1;
        run_case("R9", 1'b0);

        // R8: second start during a run is ignored.
        clear_inputs();
        req_a[7] = 4; act_a[7] = 1'b1; act_a[1] = 1'b1; spare_v = 3; act_a[13] = 1'b1;
        run_case("R8", 1'b1);

        // Random requests within budget.
        for (int t = 0; t < 25; t++) begin
            int budget = NS;
            clear_inputs();
            for (int c = 0; c < NC; c++) begin
                act_a[c] = $urandom_range(0, 1) == 1;
                if ($urandom_range(0, 2) == 0) begin
                    req_a[c] = $urandom_range(0, budget > 16 ? 16 : budget);
                    budget -= req_a[c];
                end
            end
            spare_v = $urandom_range(0, 6);
            run_case("R2", 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule